// File: doc/BRIEF.md
# Frame Alignment Monitor with Flywheel Hold

This block finds and tracks frame boundaries in a received bit stream. A line decoder upstream supplies each decoded bit together with a flag saying whether that symbol broke the alternating-polarity rule. A framing marker is a violating symbol whose decoded value is 0. While the block has no alignment it searches. The first marker it sees becomes bit position 0 of a frame of `FRAME_LEN` bits. The block then expects a marker at position 0 of every later frame. After `LOCK_COUNT` markers in a row it declares synchronisation. Once locked, it drops synchronisation when `LOSS_COUNT` expected markers in a row are missing.

A hold (flywheel) input keeps the lock in place however many markers go missing, so the frame counter keeps running on its own timing. On the transmit side the block raises a flag on the bit slot that carries the outgoing framing bit. This tells the line encoder to send that bit as a violation. A suppress input takes the flag away, so the framing bit then follows the normal alternating rule. Symbol timing comes from a one-cycle bit strobe, and every state change happens only on a strobed cycle.

Top module: `frame_sync_aligner`

## Requirements
- R1: While reset is asserted and just after it is released, `sync` is 0, `frame_pos` is 0 and the block is searching.
- R2: `frame_pos` gives the position of the next strobed bit. It advances by one on each cycle with `bit_stb` high, goes from `FRAME_LEN-1` (47) back to 0, and holds its value on cycles without a strobe.
- R3: A marker is a strobed bit with `rx_viol`=1 and `rx_bit`=0. While searching, a marker realigns the frame: that bit becomes position 0, so `frame_pos` reads 1 after it. A violation with `rx_bit`=1 is not a marker and leaves the counter unchanged.
- R4: `sync` goes to 1 on the strobe of the third marker in a row, counting the realigning marker as the first. Each later marker must arrive at position 0.
- R5: While confirming, a missing marker at position 0 sends the block back to searching with `sync` at 0. Up to that point the counter keeps running from the earlier alignment.
- R6: Once locked with `hold_sync`=0, two missing markers in a row at position 0 drop `sync` on the strobe of the second miss. A single miss followed by a marker keeps the lock.
- R7: While `hold_sync`=1 and locked, `sync` stays 1 whatever arrives at position 0, and misses seen during hold do not count toward loss.
- R8: Once confirming or locked, violations at positions other than 0 have no effect on `frame_pos` or `sync`.
- R9: `tx_viol_en` is 1 exactly when `frame_pos` is 0 and `tx_viol_off` is 0. It is 0 whenever `tx_viol_off` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| rx_bit | input | 1 | Decoded received bit value |
| rx_viol | input | 1 | Polarity-violation flag for the received symbol |
| hold_sync | input | 1 | Keep the lock regardless of missing markers |
| tx_viol_off | input | 1 | Send the framing bit without a violation |
| sync | output | 1 | Frame synchronisation achieved |
| frame_pos | output | 6 | Position within the frame of the next strobed bit |
| tx_viol_en | output | 1 | Encode the current transmit bit as a violation |

## Verification
The stream starts with unframed data at an odd offset and includes a violation whose bit is 1. This shows that the search accepts only qualified markers. A stray qualified violation then starts a false alignment that must fail at its first expected marker, which separates a correct re-search from a lock on any violation. Aligned frames carrying stray violations at other positions test that the counter ignores them once aligned. Miss patterns follow: a single miss, a double miss, and a run of misses under hold followed by misses after hold is released. These tell the loss threshold apart from the flywheel. Strobes arrive both back to back and with idle cycles between them, and the transmit suppress input is toggled along the way.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

   typedef enum logic [1:0] {
      ST_SEARCH  = 2'd0,
      ST_CONFIRM = 2'd1,
      ST_LOCKED  = 2'd2
   } fsa_state_e;

endpackage

// File: rtl/fsa_pos_counter.sv
module fsa_pos_counter #(
   parameter int FRAME_LEN = 48,
   localparam int POS_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             realign_i,
   output logic [POS_W-1:0] pos_o,
   output logic             at_marker_o
);

   localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FRAME_LEN - 1);
   localparam logic [POS_W-1:0] POS_AFTER = POS_W'(1);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (step_i) begin
         if (realign_i) begin
            pos_q <= POS_AFTER;
         end else if (pos_q == POS_LAST) begin
            pos_q <= '0;
         end else begin
            pos_q <= pos_q + POS_W'(1);
         end
      end
   end

   assign pos_o       = pos_q;
   assign at_marker_o = (pos_q == '0);

   AST_POS_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(pos_q)); // R2

   AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !realign_i && pos_q != POS_LAST) |=> pos_q == $past(pos_q) + POS_W'(1)); // R2

   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !realign_i && pos_q == POS_LAST) |=> pos_q == '0); // R2

   AST_REALIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && realign_i) |=> pos_q == POS_AFTER); // R3

endmodule

// File: rtl/fsa_sync_fsm.sv
module fsa_sync_fsm
   import fsa_pkg::*;
#(
   parameter int LOCK_COUNT  = 3,
   parameter int LOSS_COUNT  = 2,
   parameter bit HOLD_ENABLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_i,
   input  logic       mark_i,
   input  logic       at_marker_i,
   input  logic       hold_i,
   output logic       realign_o,
   output logic       sync_o,
   output fsa_state_e state_o
);

   localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
   localparam int MISS_W = $clog2(LOSS_COUNT + 1);
   localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);
   localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_COUNT - 1);
   localparam fsa_state_e FIRST_STATE = (LOCK_COUNT == 1) ? ST_LOCKED : ST_CONFIRM;

   fsa_state_e        state_q, state_d;
   logic [GOOD_W-1:0] good_q, good_d;
   logic [MISS_W-1:0] miss_q, miss_d;
   logic              hold_eff;

   generate
      if (HOLD_ENABLE) begin : g_hold
         assign hold_eff = hold_i;
      end else begin : g_no_hold
         logic unused_hold;
         assign unused_hold = hold_i;
         assign hold_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      good_d  = good_q;
      miss_d  = miss_q;
      if (step_i) begin
         unique case (state_q)
            ST_SEARCH: begin
               if (mark_i) begin
                  state_d = FIRST_STATE;
                  good_d  = GOOD_W'(1);
                  miss_d  = '0;
               end
            end
            ST_CONFIRM: begin
               if (at_marker_i) begin
                  if (!mark_i) begin
                     state_d = ST_SEARCH;
                     good_d  = '0;
                  end else if (good_q == GOOD_LAST) begin
                     state_d = ST_LOCKED;
                     miss_d  = '0;
                  end else begin
                     good_d = good_q + GOOD_W'(1);
                  end
               end
            end
            ST_LOCKED: begin
               if (at_marker_i) begin
                  if (mark_i || hold_eff) begin
                     miss_d = '0;
                  end else if (miss_q == MISS_LAST) begin
                     state_d = ST_SEARCH;
                     good_d  = '0;
                     miss_d  = '0;
                  end else begin
                     miss_d = miss_q + MISS_W'(1);
                  end
               end
            end
            default: begin
               state_d = ST_SEARCH;
               good_d  = '0;
               miss_d  = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SEARCH;
         good_q  <= '0;
         miss_q  <= '0;
      end else begin
         state_q <= state_d;
         good_q  <= good_d;
         miss_q  <= miss_d;
      end
   end

   assign realign_o = step_i && mark_i && (state_q == ST_SEARCH);
   assign sync_o    = (state_q == ST_LOCKED);
   assign state_o   = state_q;

   AST_LOCK_ON_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_o) |-> $past(step_i && mark_i)); // R4

   AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_o) |-> $past(step_i && at_marker_i && !mark_i && !hold_i)); // R6

   AST_CONFIRM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONFIRM && step_i && at_marker_i && !mark_i) |=> state_q == ST_SEARCH); // R5

   generate
      if (HOLD_ENABLE) begin : g_hold_chk
         AST_HOLD_KEEPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_o && hold_i) |=> sync_o); // R7
      end
   endgenerate

endmodule

// File: rtl/fsa_tx_flag.sv
module fsa_tx_flag (
   input  logic at_marker_i,
   input  logic suppress_i,
   output logic tx_viol_en_o
);

   assign tx_viol_en_o = at_marker_i && !suppress_i;

endmodule

// File: rtl/frame_sync_aligner.sv
module frame_sync_aligner
   import fsa_pkg::*;
#(
   parameter int FRAME_LEN    = 48,
   parameter int LOCK_COUNT   = 3,
   parameter int LOSS_COUNT   = 2,
   parameter bit HOLD_ENABLE  = 1'b1,
   parameter bit CHECK_BIT    = 1'b1,
   parameter bit MARKER_VALUE = 1'b0,
   localparam int POS_W       = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             rx_bit,
   input  logic             rx_viol,
   input  logic             hold_sync,
   input  logic             tx_viol_off,
   output logic             sync,
   output logic [POS_W-1:0] frame_pos,
   output logic             tx_viol_en
);

   generate
      if (FRAME_LEN < 4) begin : g_bad_len
         $error("frame_sync_aligner: FRAME_LEN must be at least 4");
      end
      if (LOCK_COUNT < 1) begin : g_bad_lock
         $error("frame_sync_aligner: LOCK_COUNT must be at least 1");
      end
      if (LOSS_COUNT < 1) begin : g_bad_loss
         $error("frame_sync_aligner: LOSS_COUNT must be at least 1");
      end
   endgenerate

   logic       mark;
   logic       at_marker;
   logic       realign;
   fsa_state_e state;

   generate
      if (CHECK_BIT) begin : g_mark_bit
         assign mark = rx_viol && (rx_bit == MARKER_VALUE);
      end else begin : g_mark_any
         logic unused_bit;
         assign unused_bit = rx_bit;
         assign mark       = rx_viol;
      end
   endgenerate

   fsa_pos_counter #(
      .FRAME_LEN (FRAME_LEN)
   ) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (bit_stb),
      .realign_i   (realign),
      .pos_o       (frame_pos),
      .at_marker_o (at_marker)
   );

   fsa_sync_fsm #(
      .LOCK_COUNT  (LOCK_COUNT),
      .LOSS_COUNT  (LOSS_COUNT),
      .HOLD_ENABLE (HOLD_ENABLE)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (bit_stb),
      .mark_i      (mark),
      .at_marker_i (at_marker),
      .hold_i      (hold_sync),
      .realign_o   (realign),
      .sync_o      (sync),
      .state_o     (state)
   );

   fsa_tx_flag u_tx (
      .at_marker_i  (at_marker),
      .suppress_i   (tx_viol_off),
      .tx_viol_en_o (tx_viol_en)
   );

   AST_TX_AT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
      tx_viol_en |-> (frame_pos == '0 && !tx_viol_off)); // R9

   AST_STRAY_VIOL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SEARCH && bit_stb && rx_viol && frame_pos != '0 && frame_pos != POS_W'(FRAME_LEN - 1))
      |=> frame_pos == $past(frame_pos) + POS_W'(1)); // R8

   AST_SYNC_OFF_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEARCH) |-> !sync); // R1

endmodule

// File: tb/frame_sync_aligner_bench.sv
module frame_sync_aligner_bench;

   localparam int CLK_PERIOD = 10;
   localparam int FLEN       = 48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0;
   logic       rx_bit = 1'b0;
   logic       rx_viol = 1'b0;
   logic       hold_sync = 1'b0;
   logic       tx_viol_off = 1'b0;
   logic       sync;
   logic [5:0] frame_pos;
   logic       tx_viol_en;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   int gap     = 0;
   string tag  = "R1";

   // reference model state
   int m_pos   = 0;
   int m_state = 0;   // 0 search, 1 confirm, 2 locked
   int m_good  = 0;
   int m_miss  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_sync_aligner u_frame_sync_aligner (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb     (bit_stb),
      .rx_bit      (rx_bit),
      .rx_viol     (rx_viol),
      .hold_sync   (hold_sync),
      .tx_viol_off (tx_viol_off),
      .sync        (sync),
      .frame_pos   (frame_pos),
      .tx_viol_en  (tx_viol_en)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pos = 0; m_state = 0; m_good = 0; m_miss = 0;
      end else if (bit_stb) begin
         int cur;
         bit mk;
         cur = m_pos;
         mk  = rx_viol && !rx_bit;
         m_pos = (cur + 1) % FLEN;
         if (m_state == 0) begin
            if (mk) begin m_pos = 1; m_good = 1; m_state = 1; end
         end else if (m_state == 1) begin
            if (cur == 0) begin
               if (mk) begin
                  m_good++;
                  if (m_good >= 3) begin m_state = 2; m_miss = 0; end
               end else begin
                  m_state = 0; m_good = 0;
               end
            end
         end else if (cur == 0) begin
            if (mk || hold_sync) m_miss = 0;
            else begin
               m_miss++;
               if (m_miss >= 2) begin m_state = 0; m_good = 0; m_miss = 0; end
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic cmp(input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cmp("sync", int'(sync), (m_state == 2) ? 1 : 0);
      cmp("frame_pos", int'(frame_pos), m_pos);
      cmp("tx_viol_en", int'(tx_viol_en), (m_pos == 0 && !tx_viol_off) ? 1 : 0);
   endtask

   task automatic send(input logic v, input logic b);
      for (int i = 0; i < gap; i++) begin
         bit_stb = 1'b0; rx_viol = 1'b0; rx_bit = 1'($urandom_range(0, 1));
         tick();
      end
      bit_stb = 1'b1; rx_viol = v; rx_bit = b;
      tick();
      bit_stb = 1'b0; rx_viol = 1'b0;
   endtask

   task automatic plain(input int n);
      for (int i = 0; i < n; i++) send(1'b0, 1'($urandom_range(0, 1)));
   endtask

   task automatic frame(input bit marker, input int junk);
      send(marker, 1'b0);
      for (int i = 1; i < FLEN; i++) begin
         if (junk != 0 && i == junk) send(1'b1, 1'b0);
         else send(1'b0, 1'($urandom_range(0, 1)));
      end
   endtask

   task automatic settle();
      bit_stb = 1'b0; rx_viol = 1'b0;
      tick();
   endtask

   initial begin
      tag = "R1";
      repeat (3) tick();
      @(negedge clk) rst_n = 1'b1;
      settle();
      cmp("R1 sync after reset", int'(sync), 0);
      cmp("R1 frame_pos after reset", int'(frame_pos), 0);
      cmp("R9 tx_viol_en at position 0", int'(tx_viol_en), 1);

      tag = "R2";
      repeat (5) settle();
      cmp("R2 frame_pos stable without strobe", int'(frame_pos), 0);
      plain(17);
      settle();
      cmp("R2 frame_pos after 17 bits", int'(frame_pos), 17);

      tag = "R3";
      send(1'b1, 1'b1);
      settle();
      cmp("R3 violation with bit 1 ignored", int'(frame_pos), 18);
      plain(10);
      send(1'b1, 1'b0);
      settle();
      cmp("R3 realign to violation", int'(frame_pos), 1);

      tag = "R5";
      plain(60);
      settle();
      cmp("R5 failed confirm position", int'(frame_pos), 13);
      cmp("R5 no sync after failed confirm", int'(sync), 0);

      tag = "R4";
      gap = 1;
      frame(1'b1, 0);
      frame(1'b1, 0);
      settle();
      cmp("R4 no sync after two markers", int'(sync), 0);
      send(1'b1, 1'b0);
      settle();
      cmp("R4 sync on third marker", int'(sync), 1);
      plain(FLEN - 1);
      gap = 0;

      tag = "R8";
      frame(1'b1, 20);
      frame(1'b1, 33);
      settle();
      cmp("R8 stray violations ignored pos", int'(frame_pos), 0);
      cmp("R8 stray violations ignored sync", int'(sync), 1);

      tag = "R6";
      frame(1'b0, 0);
      frame(1'b1, 0);
      settle();
      cmp("R6 single miss keeps sync", int'(sync), 1);
      frame(1'b0, 0);
      settle();
      cmp("R6 first of two misses", int'(sync), 1);
      send(1'b0, 1'b0);
      settle();
      cmp("R6 second miss drops sync", int'(sync), 0);
      plain(FLEN - 1);

      tag = "R4";
      frame(1'b1, 0);
      frame(1'b1, 0);
      frame(1'b1, 0);
      settle();
      cmp("R4 relock", int'(sync), 1);

      tag = "R7";
      hold_sync = 1'b1;
      tx_viol_off = 1'b1;
      repeat (4) frame(1'b0, 0);
      settle();
      cmp("R7 hold keeps sync", int'(sync), 1);
      cmp("R9 suppressed at position 0", int'(tx_viol_en), 0);
      tx_viol_off = 1'b0;
      settle();
      cmp("R9 enabled at position 0", int'(tx_viol_en), 1);
      hold_sync = 1'b0;
      frame(1'b0, 0);
      settle();
      cmp("R7 hold misses not counted", int'(sync), 1);
      frame(1'b0, 0);
      settle();
      cmp("R6 loss after hold released", int'(sync), 0);

      tag = "R9";
      tx_viol_off = 1'b1;
      plain(5);
      tx_viol_off = 1'b0;
      plain(50);
      settle();
      cmp("R9 away from position 0", int'(tx_viol_en), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule